// File: doc/BRIEF.md
# Auto-Precharge Write Bank Tracker

This block follows every bank of an SDRAM through a write with auto-precharge. It watches the registered command stream and keeps a state for each bank. A bank is opened with an activate command. A write-with-precharge then starts a fixed-length burst on it. When the burst finishes, the bank waits out the write-recovery time, then the precharge time, and then returns to idle, where it can be opened again.

The block also works out the column address of each data beat. The first beat is presented in the same cycle as the write command, and the later beats follow one per cycle. A write-with-precharge to a different active bank cuts the running burst short. The cut bank starts its recovery and precharge at once, while the new burst runs. Commands that do not fit a bank's state are flagged and dropped.

Top module: `apw_tracker`

## Requirements
- R1: After reset every bank reads idle (code 0), every ready bit is 1, no beat is valid and no error is flagged.
- R2: Command encoding is NOP=0, ACTIVATE=1, WRITE-AP=2, and 3 behaves as NOP. An ACTIVATE to an idle bank moves that bank to active (code 1) in the next cycle. A bank with no command stays in its state.
- R3: A WRITE-AP to an active bank raises `beat_valid_o` in the same cycle, with `beat_col_o` equal to `col_i` and `beat_bank_o` equal to `bank_i`. The bank reads writing (code 2) from the next cycle.
- R4: An uninterrupted burst gives BURST_LEN beats in consecutive cycles. The columns are col, col+1, and so on, modulo 2^COL_W.
- R5: In the cycle after the last beat the bank reads write-back (code 3) for T_WR cycles. It then reads precharge (code 4) for T_RP cycles, and then idle.
- R6: A WRITE-AP to another active bank during a burst ends that burst at once. The interrupted bank gives no further beats and enters write-back in the next cycle, then follows the R5 sequence. The new burst runs its own full length.
- R7: At most one bank is writing. Every valid beat belongs either to the write accepted in that cycle or to the bank that is writing.
- R8: A WRITE-AP to a bank that is not active raises `cmd_err_o` in the same cycle. It produces no beat and changes no bank state.
- R9: An ACTIVATE to a bank that is not idle raises `cmd_err_o` in the same cycle and changes no bank state.
- R10: `bank_ready_o[b]` is 1 exactly when bank b is idle. Bank b's state occupies bits [3b+2:3b] of `bank_state_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| cmd_i | input | 2 | Registered command code |
| bank_i | input | BANK_W | Target bank of the command |
| col_i | input | COL_W | Start column for WRITE-AP |
| beat_valid_o | output | 1 | A data beat is written this cycle |
| beat_col_o | output | COL_W | Column of the current beat |
| beat_bank_o | output | BANK_W | Bank of the current beat |
| bank_state_o | output | 3*NUM_BANKS | Packed per-bank state codes |
| bank_ready_o | output | NUM_BANKS | Bank is idle and may be activated |
| cmd_err_o | output | 1 | Command rejected and ignored |

## Verification
The assertions assume only that the command inputs are stable across each clock edge. Illegal commands are allowed because the block itself decodes and rejects them. The stimulus drives every input on the falling edge, so it stays clear of the rising edge. It sends deliberately illegal commands to idle, active and precharging banks, to check that the rejection path leaves the state untouched. Bank and column values always stay within their port widths, and the wraparound start column is chosen to cross the top of the column range.

// File: rtl/apw_pkg.sv
package apw_pkg;
  typedef enum logic [2:0] {
    BK_IDLE    = 3'd0,
    BK_ACTIVE  = 3'd1,
    BK_WRITING = 3'd2,
    BK_WRBACK  = 3'd3,
    BK_PRECH   = 3'd4
  } bank_state_e;

  typedef enum logic [1:0] {
    CMD_NOP  = 2'd0,
    CMD_ACT  = 2'd1,
    CMD_WRAP = 2'd2,
    CMD_RSVD = 2'd3
  } cmd_e;
endpackage

// File: rtl/apw_bank_fsm.sv
module apw_bank_fsm
  import apw_pkg::*;
#(
  parameter int T_WR = 2,
  parameter int T_RP = 3
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        act_i,
  input  logic        wr_i,
  input  logic        burst_end_i,
  output bank_state_e state_o
);
  localparam int TMAX  = (T_WR > T_RP) ? T_WR : T_RP;
  localparam int TMR_W = (TMAX > 1) ? $clog2(TMAX + 1) : 1;

  bank_state_e state_q, state_d;
  logic [TMR_W-1:0] tmr_q, tmr_d;

  always_comb begin
    state_d = state_q;
    tmr_d   = tmr_q;
    unique case (state_q)
      BK_IDLE:    if (act_i) state_d = BK_ACTIVE;
      BK_ACTIVE:  if (wr_i)  state_d = BK_WRITING;
      BK_WRITING: if (burst_end_i) begin
        state_d = BK_WRBACK;
        tmr_d   = TMR_W'(T_WR - 1);
      end
      BK_WRBACK: begin
        if (tmr_q == '0) begin
          state_d = BK_PRECH;
          tmr_d   = TMR_W'(T_RP - 1);
        end else tmr_d = tmr_q - 1'b1;
      end
      BK_PRECH: begin
        if (tmr_q == '0) state_d = BK_IDLE;
        else tmr_d = tmr_q - 1'b1;
      end
      default: state_d = BK_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= BK_IDLE;
      tmr_q   <= '0;
    end else begin
      state_q <= state_d;
      tmr_q   <= tmr_d;
    end
  end

  assign state_o = state_q;

  // R2
  idle_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == BK_IDLE && !act_i) |=> state_q == BK_IDLE);

  // R6
  write_exit_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == BK_WRITING) |=> (state_q == BK_WRITING || state_q == BK_WRBACK));

  // R5
  prech_done_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == BK_PRECH && tmr_q == '0) |=> state_q == BK_IDLE);
endmodule

// File: rtl/apw_burst_gen.sv
module apw_burst_gen #(
  parameter int COL_W     = 9,
  parameter int BANK_W    = 2,
  parameter int BURST_LEN = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [BANK_W-1:0] bank_i,
  input  logic [COL_W-1:0]  col_i,
  output logic              beat_valid_o,
  output logic [COL_W-1:0]  beat_col_o,
  output logic [BANK_W-1:0] beat_bank_o,
  output logic              end_o,
  output logic [BANK_W-1:0] end_bank_o
);
  localparam int CNT_W = (BURST_LEN > 1) ? $clog2(BURST_LEN) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(BURST_LEN - 1);

  logic              run_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [COL_W-1:0]  base_q;
  logic [BANK_W-1:0] bank_q;

  always_comb begin
    if (start_i) begin
      beat_valid_o = 1'b1;
      beat_col_o   = col_i;
      beat_bank_o  = bank_i;
    end else begin
      beat_valid_o = run_q;
      beat_col_o   = base_q + COL_W'(cnt_q);
      beat_bank_o  = bank_q;
    end
  end

  // running burst ends at this edge: last beat, or cut by a new write
  assign end_o      = run_q && (start_i || cnt_q == LAST);
  assign end_bank_o = bank_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q  <= 1'b0;
      cnt_q  <= '0;
      base_q <= '0;
      bank_q <= '0;
    end else if (start_i) begin
      run_q  <= (BURST_LEN > 1);
      cnt_q  <= CNT_W'(1);
      base_q <= col_i;
      bank_q <= bank_i;
    end else if (run_q) begin
      cnt_q <= cnt_q + 1'b1;
      if (cnt_q == LAST) run_q <= 1'b0;
    end
  end

  // R4
  beat_incr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_q && !start_i && cnt_q != LAST) |=>
      (start_i || (beat_valid_o && beat_col_o == $past(beat_col_o) + 1'b1)));
endmodule

// File: rtl/apw_tracker.sv
module apw_tracker
  import apw_pkg::*;
#(
  parameter int NUM_BANKS = 4,
  parameter int COL_W     = 9,
  parameter int BURST_LEN = 4,
  parameter int T_WR      = 2,
  parameter int T_RP      = 3,
  localparam int BANK_W   = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic [1:0]             cmd_i,
  input  logic [BANK_W-1:0]      bank_i,
  input  logic [COL_W-1:0]       col_i,
  output logic                   beat_valid_o,
  output logic [COL_W-1:0]       beat_col_o,
  output logic [BANK_W-1:0]      beat_bank_o,
  output logic [3*NUM_BANKS-1:0] bank_state_o,
  output logic [NUM_BANKS-1:0]   bank_ready_o,
  output logic                   cmd_err_o
);
  bank_state_e st [NUM_BANKS];
  bank_state_e tgt_st;
  logic [NUM_BANKS-1:0] writing;
  logic is_act, is_wr, act_ok, wr_ok;
  logic burst_end;
  logic [BANK_W-1:0] end_bank;

  assign tgt_st = (32'(bank_i) < NUM_BANKS) ? st[bank_i] : BK_PRECH;
  assign is_act = (cmd_i == CMD_ACT);
  assign is_wr  = (cmd_i == CMD_WRAP);
  assign act_ok = is_act && tgt_st == BK_IDLE;
  assign wr_ok  = is_wr && tgt_st == BK_ACTIVE;
  assign cmd_err_o = (is_act && !act_ok) || (is_wr && !wr_ok);

  apw_burst_gen #(
    .COL_W(COL_W), .BANK_W(BANK_W), .BURST_LEN(BURST_LEN)
  ) u_burst (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .start_i(wr_ok), .bank_i(bank_i), .col_i(col_i),
    .beat_valid_o(beat_valid_o), .beat_col_o(beat_col_o),
    .beat_bank_o(beat_bank_o), .end_o(burst_end), .end_bank_o(end_bank)
  );

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    apw_bank_fsm #(.T_WR(T_WR), .T_RP(T_RP)) u_fsm (
      .clk_i(clk_i), .rst_ni(rst_ni),
      .act_i(act_ok && bank_i == BANK_W'(b)),
      .wr_i(wr_ok && bank_i == BANK_W'(b)),
      .burst_end_i(burst_end && end_bank == BANK_W'(b)),
      .state_o(st[b])
    );
    assign bank_state_o[3*b +: 3] = st[b];
    assign bank_ready_o[b] = (st[b] == BK_IDLE);
    assign writing[b]      = (st[b] == BK_WRITING);
  end

  // R7
  one_writer_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(writing));

  // R7
  beat_src_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (beat_valid_o && !wr_ok) |-> writing[beat_bank_o]);

  // R8
  err_no_start_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_err_o && is_wr) |=> $stable(writing) || $past(burst_end));
endmodule

// File: tb/tb_apw_tracker.sv
module tb_apw_tracker;
  timeunit 1ns;
  timeprecision 1ps;

  localparam int NB = 4;
  localparam int CW = 9;
  localparam int BW = 2;
  localparam int NV = 27;

  logic clk = 1'b0, rst_ni = 1'b0;
  logic [1:0] cmd = 2'd0;
  logic [BW-1:0] bank = '0;
  logic [CW-1:0] col = '0;
  logic beat_valid, cmd_err;
  logic [CW-1:0] beat_col;
  logic [BW-1:0] beat_bank;
  logic [3*NB-1:0] bank_state;
  logic [NB-1:0] bank_ready;

  int n_chk = 0, n_bad = 0;

  always #4 clk = ~clk;

  apw_tracker dut (
    .clk_i(clk), .rst_ni(rst_ni), .cmd_i(cmd), .bank_i(bank), .col_i(col),
    .beat_valid_o(beat_valid), .beat_col_o(beat_col), .beat_bank_o(beat_bank),
    .bank_state_o(bank_state), .bank_ready_o(bank_ready), .cmd_err_o(cmd_err)
  );

  // {cmd, bank, col, exp_valid, exp_col, st3, st2, st1, st0, exp_err}
  function automatic logic [35:0] mk(input int c, b, cl, v, ec, s3, s2, s1, s0, e);
    return {2'(c), 2'(b), 9'(cl), 1'(v), 9'(ec), 3'(s3), 3'(s2), 3'(s1), 3'(s0), 1'(e)};
  endfunction

  localparam logic [35:0] VEC [NV] = '{
    mk(1,0,0,     0,0,     0,0,0,0, 0),  // R2 open bank0
    mk(1,1,0,     0,0,     0,0,0,1, 0),  // R2 open bank1
    mk(2,0,'h10,  1,'h10,  0,0,1,1, 0),  // R3 first beat same cycle
    mk(0,0,0,     1,'h11,  0,0,1,2, 0),  // R4
    mk(0,0,0,     1,'h12,  0,0,1,2, 0),  // R4
    mk(2,1,'h20,  1,'h20,  0,0,1,2, 0),  // R6 interrupt bank0
    mk(0,0,0,     1,'h21,  0,0,2,3, 0),  // R6 bank0 write-back
    mk(0,0,0,     1,'h22,  0,0,2,3, 0),
    mk(0,0,0,     1,'h23,  0,0,2,4, 0),  // R5 bank0 precharge
    mk(0,0,0,     0,0,     0,0,3,4, 0),  // R5 bank1 write-back
    mk(0,0,0,     0,0,     0,0,3,4, 0),
    mk(0,0,0,     0,0,     0,0,4,0, 0),  // R10 bank0 idle
    mk(0,0,0,     0,0,     0,0,4,0, 0),
    mk(0,0,0,     0,0,     0,0,4,0, 0),
    mk(2,2,5,     0,0,     0,0,0,0, 1),  // R8 write to idle bank
    mk(1,0,0,     0,0,     0,0,0,0, 0),  // R8 nothing changed
    mk(1,0,0,     0,0,     0,0,0,1, 1),  // R9 activate active bank
    mk(2,0,'h1FE, 1,'h1FE, 0,0,0,1, 0),  // R9 still active
    mk(0,0,0,     1,'h1FF, 0,0,0,2, 0),  // R4 wrap
    mk(0,0,0,     1,'h000, 0,0,0,2, 0),
    mk(0,0,0,     1,'h001, 0,0,0,2, 0),
    mk(0,0,0,     0,0,     0,0,0,3, 0),  // R5 full burst
    mk(0,0,0,     0,0,     0,0,0,3, 0),
    mk(1,0,0,     0,0,     0,0,0,4, 1),  // R9 activate during precharge
    mk(0,0,0,     0,0,     0,0,0,4, 0),
    mk(0,0,0,     0,0,     0,0,0,4, 0),
    mk(0,0,0,     0,0,     0,0,0,0, 0)   // R5 back to idle
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic [NB-1:0] rdy_of(input logic [11:0] s);
    logic [NB-1:0] r;
    for (int i = 0; i < NB; i++) r[i] = (s[3*i +: 3] == 3'd0);
    return r;
  endfunction

  initial begin
    repeat (2) @(negedge clk);
    #2;
    // R1
    chk("R1 state", 32'(bank_state), 0);
    chk("R1 ready", 32'(bank_ready), 32'hF);
    chk("R1 beat", 32'(beat_valid), 0);
    chk("R1 err", 32'(cmd_err), 0);
    rst_ni = 1'b1;
    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      cmd = VEC[i][35:34]; bank = VEC[i][33:32]; col = VEC[i][31:23];
      #2;
      chk($sformatf("R2/R5/R6 state v%0d", i), 32'(bank_state), 32'(VEC[i][12:1]));
      chk($sformatf("R10 ready v%0d", i), 32'(bank_ready), 32'(rdy_of(VEC[i][12:1])));
      chk($sformatf("R3/R8 valid v%0d", i), 32'(beat_valid), 32'(VEC[i][22]));
      chk($sformatf("R8/R9 err v%0d", i), 32'(cmd_err), 32'(VEC[i][0]));
      if (VEC[i][22]) chk($sformatf("R4 col v%0d", i), 32'(beat_col), 32'(VEC[i][21:13]));
    end
    // R3 beat bank on a fresh write to bank3
    @(negedge clk); cmd = 2'd1; bank = 2'd3;
    @(negedge clk); cmd = 2'd2; bank = 2'd3; col = 9'h40;
    #2;
    chk("R3 beat bank", 32'(beat_bank), 3);
    @(negedge clk); cmd = 2'd3;
    #2;
    chk("R2 reserved code as NOP col", 32'(beat_col), 32'h41);
    chk("R7 writer", 32'(bank_state[11:9]), 2);
    // R1 reset mid-burst
    rst_ni = 1'b0;
    #1;
    chk("R1 reset state", 32'(bank_state), 0);
    chk("R1 reset beat", 32'(beat_valid), 0);
    @(negedge clk); rst_ni = 1'b1; cmd = 2'd0;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule